// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address stream for bursts of four beats. Two independent start strobes, one from the processor side and one from the controller side, capture the full external address and open a burst. After that, an advance input steps a two-bit beat counter. The low two address bits are derived from the captured start bits and the beat count. The upper bits stay exactly as captured.

A run-time order input selects the ordering. In linear order the beat count is added to the start bits modulo four. In interleaved order the beat count is XOR-ed with the start bits. The order input is applied combinationally, so a change takes effect on the address in the same cycle.

The control is a small state machine. It has five states:
- `ST_IDLE`: no burst since reset.
- `ST_B0`, `ST_B1`, `ST_B2`, `ST_B3`: the first to the fourth beat.

It has four transitions:
- **start**: any state to `ST_B0` when either strobe is high.
- **step**: `ST_Bn` to `ST_Bn+1` when advance is high.
- **wrap**: `ST_B3` to `ST_B0` when advance is high.
- **hold**: any state stays put when neither strobe nor advance acts.

Top module: `burst_addr_gen`

## Requirements
- R1: After synchronous reset `burst_active` is 0 and `addr_out` is all zeros.
- R2: When `strb_cpu` or `strb_ctl` is high at a rising edge, `addr_out` equals `ext_addr` after that edge and `burst_active` is 1.
- R3: Both strobes high in the same cycle behave exactly like a single strobe: the address is loaded and the beat count restarts at zero.
- R4: A strobe takes priority over `adv` in the same cycle. While a burst is open, each edge with `adv` high and no strobe advances the beat count by one.
- R5: With `order_sel` = 0 (linear), `addr_out[1:0]` = (start low bits + beat) mod 4.
- R6: With `order_sel` = 1 (interleaved), `addr_out[1:0]` = start low bits XOR beat. `order_sel` affects the address in the same cycle.
- R7: `addr_out[ADDR_W-1:2]` stays equal to the captured upper bits for the whole burst, with no carry out of the low two bits.
- R8: An advance from the fourth beat returns the address to the first address of the burst.
- R9: With `adv` low and no strobe, `addr_out` (for an unchanged `order_sel`) and `burst_active` hold their values.
- R10: `adv` while no burst has been opened has no effect: `burst_active` stays 0 and `addr_out` stays at its reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strb_cpu | input | 1 | Processor-side burst start strobe |
| strb_ctl | input | 1 | Controller-side burst start strobe |
| adv | input | 1 | Advance to the next beat |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| ext_addr | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |
| burst_active | output | 1 | A burst has been opened |

## Verification
The bench targets the following corner cases, and what a faulty design would show on each:
- **Start bits of 3 with all upper bits set.** A design that lets the low counter carry upward corrupts the upper field.
- **More than four advances.** A design that saturates or stops at the fourth beat never returns to the start address.
- **Both strobes together, and a strobe alongside `adv`.** A design that gives `adv` priority, or treats dual strobes as a conflict, lands on the wrong beat.
- **`order_sel` toggled mid-burst, and `adv` pulsed before any burst.** The first checks that a mode latched at start is caught. The second checks that an idle counter which leaks into the address is caught.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_B0   = 3'd1,
        ST_B1   = 3'd2,
        ST_B2   = 3'd3,
        ST_B3   = 3'd4
    } beat_state_t;

    localparam int BEAT_W = 2;
endpackage

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              adv,
    output logic [BEAT_W-1:0] beat,
    output logic              active
);
    beat_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_B0;
        end else if (adv) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_B0:   state_d = ST_B1;
                ST_B1:   state_d = ST_B2;
                ST_B2:   state_d = ST_B3;
                ST_B3:   state_d = ST_B0;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        beat   = '0;
        active = 1'b1;
        unique case (state_q)
            ST_IDLE: begin beat = 2'd0; active = 1'b0; end
            ST_B0:   beat = 2'd0;
            ST_B1:   beat = 2'd1;
            ST_B2:   beat = 2'd2;
            ST_B3:   beat = 2'd3;
            default: begin beat = 2'd0; active = 1'b0; end
        endcase
    end

    AST_START_TO_B0: assert property (@(posedge clk) disable iff (rst)
        start |=> (state_q == ST_B0)); // R3
    AST_WRAP_TO_B0: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_B3 && adv && !start) |=> (state_q == ST_B0)); // R8
    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
        (!adv && !start) |=> $stable(state_q)); // R9
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE)); // R10
endmodule

// File: rtl/burst_order.sv
module burst_order
    import burst_pkg::*;
(
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_sel,
    output logic [BEAT_W-1:0] cur_lo
);
    logic [BEAT_W-1:0] lin_lo, ilv_lo;

    always_comb begin
        lin_lo = start_lo + beat;
        ilv_lo = start_lo ^ beat;
        cur_lo = order_sel ? ilv_lo : lin_lo;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strb_cpu,
    input  logic              strb_ctl,
    input  logic              adv,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_active
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic              start;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] cur_lo;

    assign start = strb_cpu | strb_ctl;

    always_ff @(posedge clk) begin
        if (rst)        base_q <= '0;
        else if (start) base_q <= ext_addr;
    end

    burst_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .adv    (adv),
        .beat   (beat),
        .active (burst_active)
    );

    burst_order u_order (
        .start_lo  (base_q[BEAT_W-1:0]),
        .beat      (beat),
        .order_sel (order_sel),
        .cur_lo    (cur_lo)
    );

    assign addr_out = {base_q[ADDR_W-1:BEAT_W], cur_lo};

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        start |=> (addr_out[ADDR_W-1:BEAT_W] == $past(ext_addr[ADDR_W-1:BEAT_W]) && burst_active)); // R2
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (burst_active && !start) |=> $stable(addr_out[ADDR_W-1:BEAT_W])); // R7
    AST_ACTIVE_KEPT: assert property (@(posedge clk) disable iff (rst)
        burst_active |=> burst_active); // R9
    initial begin
        AST_WIDTH_OK: assert (HI_W >= 1); // R7
    end
endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strb_cpu = 1'b0, strb_ctl = 1'b0, adv = 1'b0, order_sel = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] addr_out;
    logic          burst_active;

    int n_vec = 0;
    int n_bad = 0;

    // behavioural model
    int          m_active = 0;
    logic [AW-1:0] m_base = '0;
    int          m_cnt = 0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .strb_cpu(strb_cpu), .strb_ctl(strb_ctl),
        .adv(adv), .order_sel(order_sel), .ext_addr(ext_addr),
        .addr_out(addr_out), .burst_active(burst_active)
    );

    function automatic logic [AW-1:0] expect_addr();
        int lo;
        lo = m_base[1:0];
        if (order_sel) lo = lo ^ m_cnt;
        else           lo = (lo + m_cnt) % 4;
        return {m_base[AW-1:2], lo[1:0]};
    endfunction

    task automatic compare(input string tag);
        logic [AW-1:0] e;
        e = expect_addr();
        n_vec++;
        if (addr_out !== e || burst_active !== (m_active != 0)) begin
            n_bad++;
            $display("FAIL %s: addr=%h act=%0b expected addr=%h act=%0d",
                     tag, addr_out, burst_active, e, m_active);
        end
    endtask

    // call at negedge: apply inputs, clock, update model, compare at next negedge
    task automatic cyc(input logic s1, input logic s2, input logic a,
                       input logic o, input logic [AW-1:0] ad, input string tag);
        strb_cpu = s1; strb_ctl = s2; adv = a; order_sel = o; ext_addr = ad;
        @(posedge clk);
        if (s1 || s2) begin
            m_base = ad; m_cnt = 0; m_active = 1;
        end else if (a && m_active != 0) begin
            m_cnt = (m_cnt + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        compare("R1 reset");
        rst = 1'b0;
        // R10: advance before any burst
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 20'h00000, "R10 idle adv");
        // R2/R5/R8: linear, start low=2, six advances
        cyc(1, 0, 0, 0, 20'h12346, "R2 cpu strobe load");
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, 20'h0, "R5 R8 linear wrap");
        // R9: hold
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 20'hFFFFF, "R9 hold");
        // R6: interleaved, start low=1
        cyc(0, 1, 0, 1, 20'hA5A51, "R2 ctl strobe load");
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, 20'h0, "R6 R8 interleaved");
        // R7: upper all ones, low 3, linear
        cyc(1, 0, 0, 0, 20'hFFFFF, "R7 load top");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 20'h0, "R7 no carry");
        // R6: order switched mid-burst
        cyc(0, 0, 0, 1, 20'h0, "R6 live order switch");
        cyc(0, 0, 1, 0, 20'h0, "R6 live order switch");
        // R3: both strobes mid-burst
        cyc(0, 0, 1, 0, 20'h0, "R4 step");
        cyc(1, 1, 0, 0, 20'h0ABC2, "R3 both strobes");
        cyc(0, 0, 1, 0, 20'h0, "R3 count restart");
        // R4: strobe with adv wins
        cyc(1, 0, 1, 1, 20'h55557, "R4 strobe over adv");
        cyc(0, 0, 1, 1, 20'h0, "R4 step after load");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] & r[1] & r[2], r[3] & r[4] & r[5], r[6], r[7],
                r[27:8], "R4 R5 R6 R9 mixed");
        end
        // R1: reset again mid-burst
        rst = 1'b1;
        @(posedge clk);
        m_active = 0; m_base = '0; m_cnt = 0;
        @(negedge clk);
        order_sel = 1'b0;
        compare("R1 reset mid-burst");
        rst = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule